// File: doc/BRIEF.md
# Zero-Crossing Synchronized Gate Controller

This block drives the enable of an audio gate switch so that the switch only changes state when the signal passes through zero. Changing state there avoids an audible click. It takes the sign bit of the audio signal, as a comparator or the top bit of a sample stream would give it, and a single-bit trigger level from an upstream level detector. Both inputs pass through synchronizers. A registered copy of the synchronized sign yields a one-clock zero-crossing pulse on every high-to-low sign transition.

A four-state machine sequences the switch. In S_IDLE the switch is open and no trigger is seen. In S_ARMED the trigger is present and the switch is still open, waiting for a pulse. In S_PASS the switch is closed and the trigger is present. In S_HOLD the switch is closed and the trigger has gone, waiting for a pulse.

The transitions are:
- S_IDLE→S_ARMED on trigger without a pulse.
- S_IDLE→S_PASS on trigger with a pulse.
- S_ARMED→S_IDLE when the trigger is lost.
- S_ARMED→S_PASS on a pulse while the trigger is present.
- S_PASS→S_HOLD when the trigger is lost without a pulse.
- S_PASS→S_IDLE when the trigger is lost with a pulse.
- S_HOLD→S_PASS when the trigger returns.
- S_HOLD→S_IDLE on a pulse while the trigger is absent.

The switch is closed exactly in S_PASS and S_HOLD. Because the state moves only on a pulse, the switch lags both the arrival and the removal of the trigger.

Top module: `zc_gate_ctrl`

## Requirements
- R1: `zc_pulse` is high for exactly one clock cycle for each high-to-low transition of `sign_in`.
- R2: A low-to-high transition of `sign_in`, or a steady `sign_in`, produces no pulse.
- R3: While `trig_in` stays low, `switch_en` stays 0 whatever `sign_in` does.
- R4: After `trig_in` rises, `switch_en` stays 0 until a zero-crossing pulse occurs.
- R5: With the trigger present, `switch_en` becomes 1 in the cycle right after the first zero-crossing pulse.
- R6: Once `switch_en` is 1, it stays 1 after `trig_in` falls until a zero-crossing pulse occurs.
- R7: With the trigger absent, `switch_en` returns to 0 in the cycle right after the first zero-crossing pulse.
- R8: A trigger that rises and falls entirely between two pulses never sets `switch_en`.
- R9: If the trigger returns while the switch is held closed, a following pulse leaves `switch_en` at 1.
- R10: Reset forces `switch_en` to 0 and clears the edge history, so that no pulse appears in the first cycles after reset when `sign_in` is low.
- R11: Each input passes through a two-flop synchronizer. A `sign_in` change made before clock edge k shows as a pulse during the cycle after edge k+1, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_in | input | 1 | Sign of the audio signal, 1 = positive |
| trig_in | input | 1 | Trigger level from the level detector, 1 = signal present |
| switch_en | output | 1 | Gate switch enable, 1 = switch closed (audio passes) |
| zc_pulse | output | 1 | One-cycle zero-crossing pulse |

## Verification
The bench counts the exact cycle of each pulse after a sign change. A synchronizer that is one stage short or long shifts that cycle, and a pulse built without the registered copy lasts two cycles or fires on rising edges. It holds the trigger across long stretches with no zero crossing. A design that follows the trigger directly closes or opens the switch at once, with the click the block exists to prevent. It pulses the trigger briefly between crossings and drops and restores it while the switch is held closed. A machine that remembers a past trigger closes the switch late, and one that forgets the return opens it wrongly. Starting with the sign low after reset exposes an edge history that is not cleared, which would give a spurious first pulse.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,   // switch open, no trigger
        S_ARMED = 2'd1,   // switch open, trigger seen, waiting for crossing
        S_PASS  = 2'd2,   // switch closed, trigger present
        S_HOLD  = 2'd3    // switch closed, trigger gone, waiting for crossing
    } gate_state_t;
endpackage

// File: rtl/zcg_sync.sv
module zcg_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[LAST];
endmodule

// File: rtl/zcg_edge_det.sv
module zcg_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_s,
    output logic fall_pulse
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_s;
    end

    // high-to-low transition of the synchronized sign
    assign fall_pulse = prev_q & ~sig_s;
endmodule

// File: rtl/zcg_fsm.sv
module zcg_fsm
    import zcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_s,
    input  logic zc,
    output logic switch_en
);
    gate_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (trig_s && zc)  state_d = S_PASS;
                else if (trig_s)   state_d = S_ARMED;
            end
            S_ARMED: begin
                if (!trig_s)       state_d = S_IDLE;
                else if (zc)       state_d = S_PASS;
            end
            S_PASS: begin
                if (!trig_s && zc) state_d = S_IDLE;
                else if (!trig_s)  state_d = S_HOLD;
            end
            S_HOLD: begin
                if (trig_s)        state_d = S_PASS;
                else if (zc)       state_d = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            S_IDLE, S_ARMED: switch_en = 1'b0;
            S_PASS, S_HOLD:  switch_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/zc_gate_ctrl.sv
module zc_gate_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sign_in,
    input  logic trig_in,
    output logic switch_en,
    output logic zc_pulse
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] sync_in;
    logic            sign_sync;
    logic            trig_sync;

    assign raw_in    = {trig_in, sign_in};
    assign sign_sync = sync_in[0];
    assign trig_sync = sync_in[1];

    zcg_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    zcg_edge_det u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_s      (sign_sync),
        .fall_pulse (zc_pulse)
    );

    zcg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_s    (trig_sync),
        .zc        (zc_pulse),
        .switch_en (switch_en)
    );
endmodule

// File: rtl/zc_gate_ctrl_chk.sv
module zc_gate_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic trig_s,
    input logic zc_pulse,
    input logic switch_en
);
    // R1
    pulse_one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zc_pulse |=> !zc_pulse);

    // R4
    stay_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!switch_en && !zc_pulse) |=> !switch_en);

    // R3
    no_trig_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!switch_en && !trig_s) |=> !switch_en);

    // R5
    close_on_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!switch_en && zc_pulse && trig_s) |=> switch_en);

    // R6
    stay_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_en && !zc_pulse) |=> switch_en);

    // R7
    open_on_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_en && zc_pulse && !trig_s) |=> !switch_en);

    // R10
    always_comb begin
        if (!rst_n) begin
            reset_open_chk: assert (!switch_en && !zc_pulse);
        end
    end
endmodule

bind zc_gate_ctrl zc_gate_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_s    (trig_sync),
    .zc_pulse  (zc_pulse),
    .switch_en (switch_en)
);

// File: tb/zc_gate_ctrl_bench.sv
module zc_gate_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sign_in = 1'b0;
    logic trig_in = 1'b0;
    logic switch_en;
    logic zc_pulse;
    int   total = 0;
    int   bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    zc_gate_ctrl u_zc_gate_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sign_in   (sign_in),
        .trig_in   (trig_in),
        .switch_en (switch_en),
        .zc_pulse  (zc_pulse)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic actual, input logic expected);
        total++;
        if (actual !== expected) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, actual, expected, $time);
        end
    endtask

    // sign goes high (no pulse allowed), then falls; pulse timing and the
    // resulting switch state are checked.
    task automatic fall_edge(input logic exp_sw, input string req);
        sign_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R2 rising sign", zc_pulse, 1'b0);
        end
        sign_in = 1'b0;
        step();
        check("R11 pulse not early", zc_pulse, 1'b0);
        step();
        check("R1 pulse present", zc_pulse, 1'b1);
        step();
        check("R1 pulse one cycle", zc_pulse, 1'b0);
        check(req, switch_en, exp_sw);
    endtask

    task automatic t_reset();
        sign_in = 1'b0;
        trig_in = 1'b0;
        rst_n   = 1'b0;
        step();
        check("R10 switch in reset", switch_en, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R10 no pulse after reset", zc_pulse, 1'b0);
            check("R10 switch after reset", switch_en, 1'b0);
        end
    endtask

    task automatic t_no_trigger();
        trig_in = 1'b0;
        fall_edge(1'b0, "R3 open without trigger");
        fall_edge(1'b0, "R3 open without trigger");
    endtask

    task automatic t_arm_close();
        trig_in = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            check("R4 open before crossing", switch_en, 1'b0);
        end
        fall_edge(1'b1, "R5 close on crossing");
    endtask

    task automatic t_hold_release();
        trig_in = 1'b0;
        for (int i = 0; i < 10; i++) begin
            step();
            check("R6 held closed", switch_en, 1'b1);
        end
        fall_edge(1'b0, "R7 open on crossing");
    endtask

    task automatic t_brief_trigger();
        trig_in = 1'b1;
        repeat (4) step();
        trig_in = 1'b0;
        repeat (4) step();
        check("R8 brief trigger", switch_en, 1'b0);
        fall_edge(1'b0, "R8 never closes");
    endtask

    task automatic t_trigger_return();
        trig_in = 1'b1;
        repeat (4) step();
        fall_edge(1'b1, "R5 close again");
        trig_in = 1'b0;
        repeat (4) step();
        check("R6 held after drop", switch_en, 1'b1);
        trig_in = 1'b1;
        repeat (4) step();
        check("R9 trigger returned", switch_en, 1'b1);
        fall_edge(1'b1, "R9 stays closed");
        trig_in = 1'b0;
        repeat (4) step();
        fall_edge(1'b0, "R7 final open");
    endtask

    initial begin
        t_reset();
        t_no_trigger();
        t_arm_close();
        t_hold_release();
        t_brief_trigger();
        t_trigger_return();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule